// File: doc/BRIEF.md
# Overlay Memory Control Register and Address Decoder

This block sits between a Z80-style host bus and an add-on memory board that can take over the lowest 16 KB of the host's address space. It keeps a write-only control byte, loaded by an I/O write to port E3h. The control byte holds a force-map flag, a sticky RAM-as-ROM flag and a two-bit page number. From that byte, the address, the ROM-protect jumper and the automapper's `mapped_i` flag, it produces the chip selects and write permissions for the board's ROM and its 8 KB RAM pages. It also produces a signal that turns off the host's own ROM.

Three sources can bring the overlay in, each overriding the one below it. The lowest is the jumper together with the automapper, then the sticky RAM-as-ROM flag together with the automapper, and the highest is the force-map flag. In RAM-as-ROM mode the top RAM page is shown in the ROM window and cannot be written there. Outside these three cases the host keeps its normal memory map.

Top module: `ovl_map_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` all three control fields are zero. With the jumper open, no output is asserted for any address or `mapped_i` value.
- R2: The control byte is loaded at a rising clock edge when `iorq_ni` and `wr_ni` are both low and `addr_i[7:0]` equals E3h, whatever `addr_i[15:8]` holds. The new value takes effect from that edge. A different low address byte, or `iorq_ni` or `wr_ni` high, leaves the byte unchanged.
- R3: Bit 6 (RAM-as-ROM) can be set by a write but never cleared by one. Writing 0 to it after it has been set leaves it set. Only reset clears it.
- R4: With bit 7 (force-map) set, an access to 0000h–1FFFh asserts `rom_cs_o`. `rom_we_o` is high there exactly when `rom_jmp_closed_i` is 0. This holds whatever `mapped_i` and bit 6 are.
- R5: With bit 7 set, an access to 2000h–3FFFh asserts `ram_cs_o` with `ram_page_o` equal to bits 1:0, and `ram_we_o` high for every page, including page 3.
- R6: With bit 7 clear, bit 6 set and `mapped_i` high, an access to 0000h–1FFFh asserts `ram_cs_o` with page 3 and `ram_we_o` low.
- R7: In the R6 state, an access to 2000h–3FFFh selects the page in bits 1:0. `ram_we_o` is high unless that page is 3.
- R8: With bits 7 and 6 clear, `rom_jmp_closed_i` high and `mapped_i` high, 0000h–1FFFh selects the ROM with `rom_we_o` low. 2000h–3FFFh selects the banked RAM page with `ram_we_o` high.
- R9: In every other state no select or write enable is asserted and `host_rom_off_o` is low.
- R10: `host_rom_off_o` is high whenever one of the R4–R8 states holds, whatever the address and `mreq_ni` are. Selects are asserted only while `mreq_ni` is low and `addr_i` is below 4000h.
- R11: `rom_we_o` implies `rom_cs_o`, and `ram_we_o` implies `ram_cs_o`. At most one select is high at a time. `ram_page_o` is 0 whenever `ram_cs_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus-synchronous clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| addr_i | input | 16 | Host address bus |
| data_i | input | 8 | Host data bus (write data) |
| iorq_ni | input | 1 | I/O request, active low |
| wr_ni | input | 1 | Write strobe, active low |
| mreq_ni | input | 1 | Memory request, active low |
| rom_jmp_closed_i | input | 1 | ROM-protect jumper closed (ROM fitted, write-protected) |
| mapped_i | input | 1 | Automapper has mapped the overlay in |
| rom_cs_o | output | 1 | Overlay ROM select |
| rom_we_o | output | 1 | Overlay ROM write permitted |
| ram_cs_o | output | 1 | Overlay RAM select |
| ram_we_o | output | 1 | Overlay RAM write permitted |
| ram_page_o | output | 2 | Selected 8 KB RAM page |
| host_rom_off_o | output | 1 | Disable the host's own ROM |

## Verification
The assertions assume that the bus inputs settle between clock edges and that `rst_ni` is asserted before the first edge, so that the control byte starts from a defined zero. They also treat every cycle with `iorq_ni` and `wr_ni` both low as a write to whatever port is on the low address byte, so the byte is expected to stay stable in every other cycle. The bench keeps to these assumptions. It changes all inputs only on falling edges, raises `mreq_ni` throughout every I/O write, and holds each write strobe for exactly one rising edge.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_CON  = 2'd1,
    MODE_MRAM = 2'd2,
    MODE_ROM  = 2'd3
  } ovl_mode_e;

  localparam int CON_BIT  = 7;
  localparam int MRAM_BIT = 6;
endpackage

// File: rtl/ovl_ctrl_reg.sv
module ovl_ctrl_reg #(
  parameter logic [7:0] PORT_ADDR = 8'hE3,
  parameter int         BANK_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        port_i,
  input  logic [7:0]        data_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  output logic              conmem_o,
  output logic              mapram_o,
  output logic [BANK_W-1:0] bank_o
);
  import ovl_pkg::*;

  logic hit;
  logic unused_data;

  assign hit         = !iorq_ni && !wr_ni && (port_i == PORT_ADDR);
  assign unused_data = ^data_i[MRAM_BIT-1:BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conmem_o <= 1'b0;
      mapram_o <= 1'b0;
      bank_o   <= '0;
    end else if (hit) begin
      conmem_o <= data_i[CON_BIT];
      mapram_o <= mapram_o | data_i[MRAM_BIT];  // set-only
      bank_o   <= data_i[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/ovl_mode_sel.sv
module ovl_mode_sel (
  input  logic               conmem_i,
  input  logic               mapram_i,
  input  logic               rom_closed_i,
  input  logic               mapped_i,
  output ovl_pkg::ovl_mode_e mode_o
);
  import ovl_pkg::*;

  // force-map beats RAM-as-ROM beats jumper
  always_comb begin
    if (conmem_i)                     mode_o = MODE_CON;
    else if (mapram_i && mapped_i)    mode_o = MODE_MRAM;
    else if (rom_closed_i && mapped_i) mode_o = MODE_ROM;
    else                              mode_o = MODE_OFF;
  end
endmodule

// File: rtl/ovl_map_dec.sv
module ovl_map_dec #(
  parameter int BANK_W = 2
) (
  input  ovl_pkg::ovl_mode_e mode_i,
  input  logic [BANK_W-1:0]  bank_i,
  input  logic [2:0]         addr_hi_i,
  input  logic               mreq_ni,
  input  logic               rom_closed_i,
  output logic               rom_cs_o,
  output logic               rom_we_o,
  output logic               ram_cs_o,
  output logic               ram_we_o,
  output logic [BANK_W-1:0]  ram_page_o,
  output logic               host_rom_off_o
);
  import ovl_pkg::*;

  localparam logic [BANK_W-1:0] RO_PAGE = '1;

  logic in_win;
  logic upper;

  assign in_win         = !mreq_ni && (addr_hi_i[2:1] == 2'b00) && (mode_i != MODE_OFF);
  assign upper          = addr_hi_i[0];
  assign host_rom_off_o = (mode_i != MODE_OFF);

  always_comb begin
    rom_cs_o   = 1'b0;
    rom_we_o   = 1'b0;
    ram_cs_o   = 1'b0;
    ram_we_o   = 1'b0;
    ram_page_o = '0;
    if (in_win) begin
      if (upper) begin
        ram_cs_o   = 1'b1;
        ram_page_o = bank_i;
        ram_we_o   = (mode_i == MODE_MRAM) ? (bank_i != RO_PAGE) : 1'b1;
      end else begin
        unique case (mode_i)
          MODE_CON: begin
            rom_cs_o = 1'b1;
            rom_we_o = !rom_closed_i;
          end
          MODE_MRAM: begin
            ram_cs_o   = 1'b1;
            ram_page_o = RO_PAGE;
          end
          MODE_ROM: rom_cs_o = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ovl_map_ctrl.sv
module ovl_map_ctrl #(
  parameter logic [7:0] PORT_ADDR = 8'hE3,
  parameter int         ADDR_W    = 16,
  parameter int         BANK_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              iorq_ni,
  input  logic              wr_ni,
  input  logic              mreq_ni,
  input  logic              rom_jmp_closed_i,
  input  logic              mapped_i,
  output logic              rom_cs_o,
  output logic              rom_we_o,
  output logic              ram_cs_o,
  output logic              ram_we_o,
  output logic [BANK_W-1:0] ram_page_o,
  output logic              host_rom_off_o
);
  import ovl_pkg::*;

  logic              conmem_q;
  logic              mapram_q;
  logic [BANK_W-1:0] bank_q;
  ovl_mode_e         mode;
  logic              unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-4:8];

  ovl_ctrl_reg #(.PORT_ADDR(PORT_ADDR), .BANK_W(BANK_W)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .port_i   (addr_i[7:0]),
    .data_i   (data_i),
    .iorq_ni  (iorq_ni),
    .wr_ni    (wr_ni),
    .conmem_o (conmem_q),
    .mapram_o (mapram_q),
    .bank_o   (bank_q)
  );

  ovl_mode_sel u_sel (
    .conmem_i     (conmem_q),
    .mapram_i     (mapram_q),
    .rom_closed_i (rom_jmp_closed_i),
    .mapped_i     (mapped_i),
    .mode_o       (mode)
  );

  ovl_map_dec #(.BANK_W(BANK_W)) u_dec (
    .mode_i         (mode),
    .bank_i         (bank_q),
    .addr_hi_i      (addr_i[ADDR_W-1:ADDR_W-3]),
    .mreq_ni        (mreq_ni),
    .rom_closed_i   (rom_jmp_closed_i),
    .rom_cs_o       (rom_cs_o),
    .rom_we_o       (rom_we_o),
    .ram_cs_o       (ram_cs_o),
    .ram_we_o       (ram_we_o),
    .ram_page_o     (ram_page_o),
    .host_rom_off_o (host_rom_off_o)
  );
endmodule

// File: rtl/ovl_map_ctrl_chk.sv
module ovl_map_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              iorq_ni,
  input logic              wr_ni,
  input logic              mreq_ni,
  input logic              conmem_q,
  input logic              mapram_q,
  input logic [BANK_W-1:0] bank_q,
  input logic              rom_cs_o,
  input logic              rom_we_o,
  input logic              ram_cs_o,
  input logic              ram_we_o,
  input logic [BANK_W-1:0] ram_page_o,
  input logic              host_rom_off_o
);
  a_r3_mapram_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mapram_q |=> mapram_q);

  a_r2_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iorq_ni || wr_ni) |=> ($stable(conmem_q) && $stable(mapram_q) && $stable(bank_q)));

  a_r11_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ram_cs_o}));

  a_r11_we_needs_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_we_o || rom_cs_o) && (!ram_we_o || ram_cs_o));

  a_r11_page_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_cs_o |-> (ram_page_o == '0));

  a_r10_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mreq_ni || (addr_i[ADDR_W-1:ADDR_W-2] != 2'b00)) |-> (!rom_cs_o && !ram_cs_o));

  a_r9_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_rom_off_o |-> (!rom_cs_o && !ram_cs_o));

  a_r6_top_page_ro: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_cs_o && !conmem_q && mapram_q && (ram_page_o == '1)) |-> !ram_we_o);

  a_r5_conmem_ram_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conmem_q && ram_cs_o) |-> ram_we_o);
endmodule

bind ovl_map_ctrl ovl_map_ctrl_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .addr_i         (addr_i),
  .iorq_ni        (iorq_ni),
  .wr_ni          (wr_ni),
  .mreq_ni        (mreq_ni),
  .conmem_q       (conmem_q),
  .mapram_q       (mapram_q),
  .bank_q         (bank_q),
  .rom_cs_o       (rom_cs_o),
  .rom_we_o       (rom_we_o),
  .ram_cs_o       (ram_cs_o),
  .ram_we_o       (ram_we_o),
  .ram_page_o     (ram_page_o),
  .host_rom_off_o (host_rom_off_o)
);

// File: tb/sim_ovl_map_ctrl.sv
`timescale 1ns/1ps
module sim_ovl_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        iorq_n = 1'b1, wr_n = 1'b1, mreq_n = 1'b1;
  logic        jmp = 1'b0, mapped = 1'b0;
  logic        rom_cs, rom_we, ram_cs, ram_we, host_off;
  logic [1:0]  page;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  ovl_map_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data),
    .iorq_ni(iorq_n), .wr_ni(wr_n), .mreq_ni(mreq_n),
    .rom_jmp_closed_i(jmp), .mapped_i(mapped),
    .rom_cs_o(rom_cs), .rom_we_o(rom_we), .ram_cs_o(ram_cs),
    .ram_we_o(ram_we), .ram_page_o(page), .host_rom_off_o(host_off)
  );

  // expected = {host_off, rom_cs, rom_we, ram_cs, ram_we, page[1:0]}
  typedef struct packed {
    logic [7:0]  dat;
    logic        jmp;
    logic        map;
    logic [15:0] adr;
    logic [6:0]  exp;
  } row_t;

  localparam row_t ROWS [15] = '{
    '{8'h80, 1'b0, 1'b0, 16'h0100, 7'b1110000},  // R4 open jumper
    '{8'h80, 1'b1, 1'b0, 16'h0100, 7'b1100000},  // R4 closed jumper
    '{8'h82, 1'b1, 1'b0, 16'h2345, 7'b1001110},  // R5
    '{8'h00, 1'b1, 1'b1, 16'h0038, 7'b1100000},  // R8 low
    '{8'h03, 1'b1, 1'b1, 16'h3FFF, 7'b1001111},  // R8 high
    '{8'h03, 1'b1, 1'b0, 16'h3000, 7'b0000000},  // R9 not mapped
    '{8'h01, 1'b0, 1'b1, 16'h1000, 7'b0000000},  // R9 jumper open
    '{8'h83, 1'b0, 1'b0, 16'h5000, 7'b1000000},  // R10 above window
    '{8'h41, 1'b0, 1'b1, 16'h0000, 7'b1001011},  // R6
    '{8'h41, 1'b0, 1'b1, 16'h2000, 7'b1001101},  // R7 page 1
    '{8'h43, 1'b1, 1'b1, 16'h2100, 7'b1001011},  // R7 page 3 ro
    '{8'h43, 1'b1, 1'b0, 16'h0000, 7'b0000000},  // R9 mapram unmapped
    '{8'hC3, 1'b0, 1'b0, 16'h0010, 7'b1110000},  // R4 beats mapram
    '{8'hC3, 1'b0, 1'b0, 16'h2000, 7'b1001111},  // R5 page 3 writable
    '{8'h02, 1'b0, 1'b1, 16'h0000, 7'b1001011}   // R3 bit 6 stays set
  };

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    mreq_n = 1'b1; addr = a; data = d; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic check(input string req, input logic j, input logic m,
                       input logic mq_n, input logic [15:0] a, input logic [6:0] exp);
    logic [6:0] act;
    @(negedge clk);
    jmp = j; mapped = m; mreq_n = mq_n; addr = a;
    #1;
    act = {host_off, rom_cs, rom_we, ram_cs, ram_we, page};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h act=%b exp=%b", req, a, act, exp);
    end
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", 1'b0, 1'b1, 1'b0, 16'h0000, 7'b0000000);
    check("R1", 1'b1, 1'b1, 1'b0, 16'h2000, 7'b1001100);

    for (int i = 0; i < 15; i++) begin
      io_wr(16'h00E3, ROWS[i].dat);
      check($sformatf("table row %0d", i), ROWS[i].jmp, ROWS[i].map,
            1'b0, ROWS[i].adr, ROWS[i].exp);
    end

    // reset clears sticky bit
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R1 after reset", 1'b0, 1'b1, 1'b0, 16'h0000, 7'b0000000);

    // R2 upper address byte ignored
    io_wr(16'h7FE3, 8'h80);
    check("R2 upper byte", 1'b0, 1'b0, 1'b0, 16'h0000, 7'b1110000);
    io_wr(16'h00E2, 8'h00);
    check("R2 wrong port", 1'b0, 1'b0, 1'b0, 16'h0000, 7'b1110000);
    @(negedge clk);
    mreq_n = 1'b1; addr = 16'h00E3; data = 8'h00; iorq_n = 1'b0; wr_n = 1'b1;
    @(negedge clk); iorq_n = 1'b1;
    check("R2 no wr", 1'b0, 1'b0, 1'b0, 16'h0000, 7'b1110000);
    @(negedge clk);
    mreq_n = 1'b1; addr = 16'h00E3; data = 8'h00; iorq_n = 1'b1; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    check("R2 no iorq", 1'b0, 1'b0, 1'b0, 16'h0000, 7'b1110000);

    // R10 select gating, host ROM off held
    check("R10 mreq high", 1'b0, 1'b0, 1'b1, 16'h0000, 7'b1000000);
    check("R10 addr 4000", 1'b0, 1'b0, 1'b0, 16'h4000, 7'b1000000);
    // R11 page forced to 0 while RAM idle (bank 3 loaded)
    io_wr(16'h00E3, 8'h83);
    check("R11 idle page", 1'b1, 1'b0, 1'b0, 16'h1FFF, 7'b1100000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule